// File: doc/BRIEF.md
# Watch Timebase with Tone Output

This block is a clock-of-day timebase. It divides a nominal 32.768 kHz time reference down to a request flag that is raised once every half second. The reference is taken either from strobes that mark each period of a slow crystal clock, or from the block clock itself divided by 128. A fast setting raises the flag 128 times as often, about every 3.91 ms, which shortens software and hardware tests. A fixed tone at one sixteenth of the reference rate can be sent to a shared output pin in place of that pin's ordinary port value.

Software programs one mode register. In it, a run bit, a reference select bit, a fast bit and a tone enable bit are stored, and a self-clearing restart bit restarts the divider phase, so that counting begins at a zero-second instant. The request flag is sticky. It stays set until an acknowledge pulse removes it, and it can be used to wake the chip from standby. While the chip is stopped, the block clock's own reference is frozen, but the slow-crystal reference keeps running.

Top module: `wtk_watch_unit`

## Requirements
- R1: After reset the stored mode is all zero, the request flag `irq_o` is low, and `buz_o` follows `port_latch_i`.
- R2: With run=1 (bit0), the slow reference selected (bit1=1) and fast=0 (bit2), `irq_o` rises on exactly the 16384th accepted `sub_tick_i` pulse after a restart.
- R3: With fast=1 (bit2), `irq_o` rises on exactly the 128th accepted reference tick after a restart.
- R4: With bit1=0, one reference tick is produced every 128 clock edges, so in fast mode `irq_o` rises exactly 16384 clock edges after the restart edge.
- R5: With tone enable (bit3) set and `port_out_mode_i` high, `buz_o` is the divider's bit 3: after a restart it is low for 8 reference ticks and then high for 8, a square wave at one sixteenth of the reference rate.
- R6: When tone enable is clear or `port_out_mode_i` is low, `buz_o` equals `port_latch_i`.
- R7: A mode write with bit4 set clears the divider and the block-clock prescaler on that edge. A flag set that falls on the same edge is suppressed, and a full period counted from that edge must pass before the flag rises.
- R8: While run=0, reference ticks are ignored and the divider holds its count. Setting run again without a restart resumes from the held count.
- R9: While `stop_i` is high, the block-clock reference is frozen, and the slow reference keeps counting and can still raise `irq_o`.
- R10: `irq_o` stays set until an `irq_ack_i` pulse. When a set and an acknowledge fall on the same edge, the set wins.
- R11: Ticks from the reference that is not selected have no effect on the count or on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the fast reference before division |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick_i | input | 1 | One-cycle strobe per slow crystal period |
| stop_i | input | 1 | Chip is in stop standby (block-clock reference halted) |
| mode_wr_i | input | 1 | Write strobe for the mode register |
| mode_wdata_i | input | 5 | bit0 run, bit1 slow reference, bit2 fast, bit3 tone enable, bit4 restart |
| irq_ack_i | input | 1 | Clears the request flag |
| port_latch_i | input | 1 | Port output latch value for the shared pin |
| port_out_mode_i | input | 1 | Shared pin is in output mode |
| irq_o | output | 1 | Sticky request flag |
| buz_o | output | 1 | Shared pin value: tone or port latch |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a restart write and the terminal reference tick. The bench delivers the 128th fast-mode tick in the very cycle of the restart write, and then expects the flag to stay low and to need a further 128 ticks. The second pair is an acknowledge and a fresh set. With the flag already high, the bench pulses the acknowledge together with the terminal tick and expects the flag to remain set.

// File: rtl/wtk_pkg.sv
package wtk_pkg;
   localparam int MODE_W      = 5;
   localparam int BIT_RUN     = 0;
   localparam int BIT_SRC_SUB = 1;
   localparam int BIT_FAST    = 2;
   localparam int BIT_TONE    = 3;
   localparam int BIT_RESTART = 4;

   typedef struct packed {
      logic tone_en;
      logic fast;
      logic src_sub;
      logic run;
   } wtk_mode_t;

   function automatic wtk_mode_t wtk_decode(input logic [MODE_W-1:0] w);
      wtk_mode_t m;
      m.run     = w[BIT_RUN];
      m.src_sub = w[BIT_SRC_SUB];
      m.fast    = w[BIT_FAST];
      m.tone_en = w[BIT_TONE];
      return m;
   endfunction
endpackage

// File: rtl/wtk_prescale.sv
module wtk_prescale #(
   parameter int DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic clr_i,
   output logic tick_o
);
   if (DIV < 1) begin : g_bad_div
      $error("wtk_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick_o = en_i & ~clr_i;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clr_i) begin
            cnt_q <= '0;
         end else if (en_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end

      assign tick_o = en_i & ~clr_i & (cnt_q == LAST);
   end
endmodule

// File: rtl/wtk_divider.sv
module wtk_divider #(
   parameter int DIV_W    = 14,
   parameter int FAST_TAP = 7,
   parameter int TONE_TAP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             restart_i,
   input  logic             fast_i,
   output logic             term_o,
   output logic             tone_o,
   output logic [DIV_W-1:0] cnt_o
);
   if (FAST_TAP < 1 || FAST_TAP > DIV_W) begin : g_bad_fast
      $error("wtk_divider: FAST_TAP out of range");
   end
   if (TONE_TAP < 1 || TONE_TAP > DIV_W) begin : g_bad_tone
      $error("wtk_divider: TONE_TAP out of range");
   end

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   logic full_term;
   logic fast_term;
   assign full_term = &cnt_q;

   if (FAST_TAP == DIV_W) begin : g_fast_full
      assign fast_term = full_term;
   end else begin : g_fast_part
      assign fast_term = &cnt_q[FAST_TAP-1:0];
   end

   assign term_o = fast_i ? fast_term : full_term;
   assign tone_o = cnt_q[TONE_TAP-1];
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/wtk_pin_mux.sv
module wtk_pin_mux (
   input  logic tone_en_i,
   input  logic out_mode_i,
   input  logic tone_i,
   input  logic latch_i,
   output logic pin_o
);
   logic use_tone;
   assign use_tone = tone_en_i & out_mode_i;
   assign pin_o    = use_tone ? tone_i : latch_i;
endmodule

// File: rtl/wtk_watch_unit.sv
module wtk_watch_unit
   import wtk_pkg::*;
#(
   parameter int MAIN_DIV = 128,
   parameter int DIV_W    = 14,
   parameter int FAST_TAP = 7,
   parameter int TONE_TAP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_tick_i,
   input  logic              stop_i,
   input  logic              mode_wr_i,
   input  logic [MODE_W-1:0] mode_wdata_i,
   input  logic              irq_ack_i,
   input  logic              port_latch_i,
   input  logic              port_out_mode_i,
   output logic              irq_o,
   output logic              buz_o
);
   wtk_mode_t        mode_q;
   logic             restart;
   logic             main_en;
   logic             main_tick;
   logic             fw_tick;
   logic             term;
   logic             tone;
   logic             flag_set;
   logic [DIV_W-1:0] div_cnt;

   assign restart = mode_wr_i & mode_wdata_i[BIT_RESTART];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (mode_wr_i) begin
         mode_q <= wtk_decode(mode_wdata_i);
      end
   end

   assign main_en = mode_q.run & ~mode_q.src_sub & ~stop_i;

   wtk_prescale #(.DIV(MAIN_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (main_en),
      .clr_i  (restart),
      .tick_o (main_tick)
   );

   assign fw_tick = mode_q.run & (mode_q.src_sub ? sub_tick_i : main_tick);

   wtk_divider #(
      .DIV_W    (DIV_W),
      .FAST_TAP (FAST_TAP),
      .TONE_TAP (TONE_TAP)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (fw_tick),
      .restart_i (restart),
      .fast_i    (mode_q.fast),
      .term_o    (term),
      .tone_o    (tone),
      .cnt_o     (div_cnt)
   );

   assign flag_set = fw_tick & term & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
      end else if (flag_set) begin
         irq_o <= 1'b1;
      end else if (irq_ack_i) begin
         irq_o <= 1'b0;
      end
   end

   wtk_pin_mux u_mux (
      .tone_en_i  (mode_q.tone_en),
      .out_mode_i (port_out_mode_i),
      .tone_i     (tone),
      .latch_i    (port_latch_i),
      .pin_o      (buz_o)
   );
endmodule

// File: rtl/wtk_watch_unit_chk.sv
module wtk_watch_unit_chk #(
   parameter int DIV_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             src_sub,
   input logic             stop_i,
   input logic             mode_wr_i,
   input logic             restart,
   input logic             fw_tick,
   input logic             irq_ack_i,
   input logic             irq_o,
   input logic [DIV_W-1:0] div_cnt
);
   p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_ack_i) |=> irq_o);

   p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !irq_o) |=> !irq_o);

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !mode_wr_i) |=> $stable(div_cnt));

   p_stop_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !src_sub && !mode_wr_i) |=> $stable(div_cnt));

   p_rise_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && fw_tick == 1'b0) |=> !irq_o);
endmodule

bind wtk_watch_unit wtk_watch_unit_chk #(.DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (mode_q.run),
   .src_sub   (mode_q.src_sub),
   .stop_i    (stop_i),
   .mode_wr_i (mode_wr_i),
   .restart   (restart),
   .fw_tick   (fw_tick),
   .irq_ack_i (irq_ack_i),
   .irq_o     (irq_o),
   .div_cnt   (div_cnt)
);

// File: tb/wtk_watch_unit_test.sv
module wtk_watch_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sub_tick = 1'b0;
   logic       stop = 1'b0;
   logic       mode_wr = 1'b0;
   logic [4:0] mode_wdata = '0;
   logic       irq_ack = 1'b0;
   logic       port_latch = 1'b0;
   logic       port_out = 1'b0;
   logic       irq;
   logic       buz;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // mode bits: 0 run, 1 slow reference, 2 fast, 3 tone, 4 restart
   localparam logic [4:0] M_RUN = 5'b00001;
   localparam logic [4:0] M_SUB = 5'b00010;
   localparam logic [4:0] M_FST = 5'b00100;
   localparam logic [4:0] M_TON = 5'b01000;
   localparam logic [4:0] M_RST = 5'b10000;

   always #2 clk = ~clk;

   wtk_watch_unit uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .sub_tick_i      (sub_tick),
      .stop_i          (stop),
      .mode_wr_i       (mode_wr),
      .mode_wdata_i    (mode_wdata),
      .irq_ack_i       (irq_ack),
      .port_latch_i    (port_latch),
      .port_out_mode_i (port_out),
      .irq_o           (irq),
      .buz_o           (buz)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic write_mode(input logic [4:0] v);
      @(negedge clk);
      mode_wr = 1'b1;
      mode_wdata = v;
      @(negedge clk);
      mode_wr = 1'b0;
      mode_wdata = '0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sub_tick = 1'b1;
         @(negedge clk);
         sub_tick = 1'b0;
      end
   endtask

   task automatic ack();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 irq after reset", irq, 1'b0);
      port_latch = 1'b1;
      port_out = 1'b1;
      #1;
      check("R1 pin follows latch", buz, 1'b1);
      port_latch = 1'b0;
      #1;
      check("R1 pin follows latch low", buz, 1'b0);
   endtask

   task automatic t_normal_sub();
      write_mode(M_RUN | M_SUB | M_RST);
      ticks(16383);
      check("R2 no flag at 16383", irq, 1'b0);
      ticks(1);
      check("R2 flag at 16384", irq, 1'b1);
      ticks(5);
      check("R10 flag sticky", irq, 1'b1);
      ack();
      check("R10 ack clears", irq, 1'b0);
   endtask

   task automatic t_fast_sub();
      write_mode(M_RUN | M_SUB | M_FST | M_RST);
      repeat (3000) @(negedge clk);
      check("R11 idle block clock ignored", irq, 1'b0);
      ticks(127);
      check("R3 no flag at 127", irq, 1'b0);
      ticks(1);
      check("R3 flag at 128", irq, 1'b1);
      ack();
   endtask

   task automatic t_restart_collide();
      write_mode(M_RUN | M_SUB | M_FST | M_RST);
      ticks(127);
      @(negedge clk);
      sub_tick = 1'b1;
      mode_wr = 1'b1;
      mode_wdata = M_RUN | M_SUB | M_FST | M_RST;
      @(negedge clk);
      sub_tick = 1'b0;
      mode_wr = 1'b0;
      mode_wdata = '0;
      check("R7 set suppressed by restart", irq, 1'b0);
      ticks(127);
      check("R7 full period after restart", irq, 1'b0);
      ticks(1);
      check("R7 flag after restart period", irq, 1'b1);
      // set and ack on one edge: set wins
      ticks(127);
      @(negedge clk);
      sub_tick = 1'b1;
      irq_ack = 1'b1;
      @(negedge clk);
      sub_tick = 1'b0;
      irq_ack = 1'b0;
      check("R10 set beats ack", irq, 1'b1);
      ack();
   endtask

   task automatic t_disable();
      write_mode(M_RUN | M_SUB | M_FST | M_RST);
      ticks(100);
      write_mode(M_SUB | M_FST);
      ticks(50);
      check("R8 no flag while idle", irq, 1'b0);
      write_mode(M_RUN | M_SUB | M_FST);
      ticks(27);
      check("R8 resume held count", irq, 1'b0);
      ticks(1);
      check("R8 flag after resume", irq, 1'b1);
      ack();
   endtask

   task automatic t_tone();
      port_out = 1'b1;
      port_latch = 1'b1;
      write_mode(M_RUN | M_SUB | M_TON | M_RST);
      check("R5 tone low after restart", buz, 1'b0);
      ticks(7);
      check("R5 tone low at 7", buz, 1'b0);
      ticks(1);
      check("R5 tone high at 8", buz, 1'b1);
      ticks(8);
      check("R5 tone low at 16", buz, 1'b0);
      port_out = 1'b0;
      #1;
      check("R6 input mode uses latch", buz, 1'b1);
      port_out = 1'b1;
      write_mode(M_RUN | M_SUB);
      port_latch = 1'b0;
      ticks(8);
      check("R6 tone off uses latch", buz, 1'b0);
      port_latch = 1'b1;
      #1;
      check("R6 tone off latch high", buz, 1'b1);
      port_latch = 1'b0;
   endtask

   task automatic t_main_stop();
      write_mode(M_RUN | M_FST | M_RST);
      ticks(300);
      check("R11 slow ticks ignored", irq, 1'b0);
      // 300 ticks took 600 edges; 16384 edges in total
      repeat (7000) @(negedge clk);
      stop = 1'b1;
      repeat (5000) @(negedge clk);
      check("R9 frozen in stop", irq, 1'b0);
      stop = 1'b0;
      repeat (16384 - 600 - 7000 - 1) @(negedge clk);
      check("R4 no flag one edge early", irq, 1'b0);
      @(negedge clk);
      check("R4 flag at 16384 edges", irq, 1'b1);
      ack();
      write_mode(M_RUN | M_SUB | M_FST | M_RST);
      stop = 1'b1;
      ticks(128);
      check("R9 slow reference runs in stop", irq, 1'b1);
      stop = 1'b0;
      ack();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_normal_sub();
      t_fast_sub();
      t_restart_collide();
      t_disable();
      t_tone();
      t_main_stop();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(posedge clk);
            failures++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule